// File: doc/BRIEF.md
# Stop-Mode Wake-Up Controller

This block sits beside a small processor core and manages its low-power stop mode. When the core requests stop, the block drops its clock-enable, which gates the oscillator. It then watches three wake sources: a maskable interrupt line, a second interrupt line that always wakes the part, and an external reset. The block samples the core's two mask bits and reports one of three actions to the core when it wakes: service the interrupt, resume at the instruction after the stop, or restart completely.

An optional oscillator-stabilization delay can be placed before the clock is released. A delay-enable bit controls it. Every reset sets this bit, and software may clear it while the core runs. A power-on reset always applies the delay. A reset that leaves stop sets the bit again, so that wake also applies the delay. A reset that arrives while the clock runs never stops the clock. The delay is a fixed number of oscillator cycles, counted by a down-counter. When the clock comes back, a single-cycle ready pulse marks the event.

Top module: `stop_wake_ctrl`

## Requirements
- R1: While stopped, the maskable line `irq_lvl` wakes the block only when `mask_i` is 0. With `mask_i` = 1 it leaves `clk_en` at 0 for as long as it is held.
- R2: While stopped, the line `nmi_lvl` wakes the block whatever the value of `mask_x`.
- R3: A wake from `nmi_lvl` with `mask_x` = 0 reports `wake_act` = 1 (service interrupt). An accepted wake from `irq_lvl` also reports 1.
- R4: A wake from `nmi_lvl` with `mask_x` = 1 reports `wake_act` = 2 (resume after stop). No service code is reported for that wake.
- R5: `dly_en` reads 1 in the cycle after `por` or `rst_ext`. While running, a write (`dly_we` with `dly_d`) changes it in the next cycle.
- R6: When an interrupt wake is sampled at edge E0, `clk_en` rises at edge E0 if `dly_en` = 0. If `dly_en` = 1 it rises at edge E0+STAB_CYCLES+1.
- R7: `por` holds `clk_en` = 0, `ready` = 0, `dly_en` = 1 and `wake_act` = 3. After the last edge that samples `por` high, `clk_en` rises STAB_CYCLES+1 edges later. This holds whatever `dly_en` was before.
- R8: `rst_ext` while running keeps `clk_en` at 1 and produces no `ready` pulse. It sets `wake_act` to 0 (none).
- R9: `rst_ext` while stopped reports `wake_act` = 3 (restart) and sets `dly_en`. It applies the full delay even if `dly_en` was 0.
- R10: When several wake sources arrive in the same cycle, the priority is `rst_ext`, then `nmi_lvl`, then an unmasked `irq_lvl`.
- R11: While running, `stop_req` drops `clk_en` at the next edge and sets `wake_act` to 0. It has no effect while a wake condition is active: `rst_ext`, `nmi_lvl`, or `irq_lvl` with `mask_i` = 0.
- R12: `ready` is high for exactly one cycle, in the cycle in which `clk_en` first returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst_ext | input | 1 | External reset, synchronous, active high |
| stop_req | input | 1 | Stop request from the core |
| irq_lvl | input | 1 | Maskable interrupt line, active high |
| nmi_lvl | input | 1 | Second interrupt line, active high |
| mask_i | input | 1 | Core mask bit for `irq_lvl` |
| mask_x | input | 1 | Core mask bit for `nmi_lvl` |
| dly_we | input | 1 | Write strobe for the delay-enable bit |
| dly_d | input | 1 | Value written to the delay-enable bit |
| clk_en | output | 1 | Clock-enable to the oscillator gate |
| wake_act | output | 2 | 0 none, 1 service, 2 resume, 3 restart |
| ready | output | 1 | One-cycle pulse when clocks resume |
| dly_en | output | 1 | Current delay-enable bit |

## Verification
Two functions can fall in the same cycle here.

- **Stop request and wake condition.** A stop request can arrive in the same cycle as a wake condition that would cancel it. The bench raises `stop_req` together with an unmasked `irq_lvl`, and separately together with `nmi_lvl`. It judges the result by `clk_en` staying high and `wake_act` staying unchanged.
- **Competing wake sources.** Several wake sources can be sampled by the same edge while the block is stopped. Table rows drive `rst_ext`, `nmi_lvl` and `irq_lvl` together in different combinations. The priority is judged from the reported action code and from the number of edges until `clk_en` returns.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_STAB = 2'd2
  } state_e;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_SERVICE = 2'd1,
    ACT_RESUME  = 2'd2,
    ACT_RESTART = 2'd3
  } act_e;
endpackage

// File: rtl/swc_wake_arb.sv
module swc_wake_arb
  import swc_pkg::*;
(
  input  logic rst_ext,
  input  logic nmi_lvl,
  input  logic irq_lvl,
  input  logic mask_i,
  input  logic mask_x,
  output logic hit,
  output act_e act
);
  // Fixed priority: reset, then the unmaskable-for-wake line, then the maskable one.
  always_comb begin
    hit = 1'b0;
    act = ACT_NONE;
    if (rst_ext) begin
      hit = 1'b1;
      act = ACT_RESTART;
    end else if (nmi_lvl) begin
      hit = 1'b1;
      act = mask_x ? ACT_RESUME : ACT_SERVICE;
    end else if (irq_lvl && !mask_i) begin
      hit = 1'b1;
      act = ACT_SERVICE;
    end
  end
endmodule

// File: rtl/swc_stab_timer.sv
module swc_stab_timer #(
  parameter int STAB_CYCLES = 64
) (
  input  logic clk,
  input  logic load,
  output logic zero
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(STAB_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load)
      cnt <= LOAD_VAL;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/swc_dly_reg.sv
module swc_dly_reg (
  input  logic clk,
  input  logic any_rst,
  input  logic wr_ok,
  input  logic dly_we,
  input  logic dly_d,
  output logic dly_q
);
  always_ff @(posedge clk) begin
    if (any_rst)
      dly_q <= 1'b1;
    else if (wr_ok && dly_we)
      dly_q <= dly_d;
  end
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swc_pkg::*;
#(
  parameter int STAB_CYCLES = 64
) (
  input  logic       clk,
  input  logic       por,
  input  logic       rst_ext,
  input  logic       stop_req,
  input  logic       irq_lvl,
  input  logic       nmi_lvl,
  input  logic       mask_i,
  input  logic       mask_x,
  input  logic       dly_we,
  input  logic       dly_d,
  output logic       clk_en,
  output logic [1:0] wake_act,
  output logic       ready,
  output logic       dly_en
);
  state_e state;
  act_e   act_q;
  act_e   arb_act;
  logic   arb_hit;
  logic   tmr_zero;
  logic   tmr_load;

  swc_wake_arb u_arb (
    .rst_ext (rst_ext),
    .nmi_lvl (nmi_lvl),
    .irq_lvl (irq_lvl),
    .mask_i  (mask_i),
    .mask_x  (mask_x),
    .hit     (arb_hit),
    .act     (arb_act)
  );

  // Counter restarts on power-on, on a delayed wake, and on reset during the delay.
  assign tmr_load = por
                  | ((state == ST_STOP) && arb_hit && (rst_ext || dly_en))
                  | ((state == ST_STAB) && rst_ext);

  swc_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_tmr (
    .clk  (clk),
    .load (tmr_load),
    .zero (tmr_zero)
  );

  swc_dly_reg u_dly (
    .clk     (clk),
    .any_rst (por | rst_ext),
    .wr_ok   (state == ST_RUN),
    .dly_we  (dly_we),
    .dly_d   (dly_d),
    .dly_q   (dly_en)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      state  <= ST_STAB;
      clk_en <= 1'b0;
      ready  <= 1'b0;
      act_q  <= ACT_RESTART;
    end else begin
      ready <= 1'b0;
      unique case (state)
        ST_RUN: begin
          if (rst_ext) begin
            act_q <= ACT_NONE;
          end else if (stop_req && !arb_hit) begin
            state  <= ST_STOP;
            clk_en <= 1'b0;
            act_q  <= ACT_NONE;
          end
        end
        ST_STOP: begin
          if (arb_hit) begin
            act_q <= arb_act;
            if (rst_ext || dly_en) begin
              state <= ST_STAB;
            end else begin
              state  <= ST_RUN;
              clk_en <= 1'b1;
              ready  <= 1'b1;
            end
          end
        end
        ST_STAB: begin
          if (rst_ext) begin
            act_q <= ACT_RESTART;
          end else if (tmr_zero) begin
            state  <= ST_RUN;
            clk_en <= 1'b1;
            ready  <= 1'b1;
          end
        end
        default: state <= ST_STAB;
      endcase
    end
  end

  assign wake_act = act_q;
endmodule

// File: rtl/swc_checker.sv
module swc_checker
  import swc_pkg::*;
(
  input logic       clk,
  input logic       por,
  input logic       rst_ext,
  input logic       stop_req,
  input logic       irq_lvl,
  input logic       nmi_lvl,
  input logic       mask_i,
  input logic       mask_x,
  input logic       clk_en,
  input logic [1:0] wake_act,
  input logic       ready,
  input logic       dly_en,
  input state_e     state
);
  a_r1_masked_irq_stays: assert property (@(posedge clk) disable iff (por)
    (state == ST_STOP && irq_lvl && mask_i && !nmi_lvl && !rst_ext) |=> (state == ST_STOP && !clk_en));

  a_r4_resume_code: assert property (@(posedge clk) disable iff (por)
    (state == ST_STOP && nmi_lvl && mask_x && !rst_ext) |=> (wake_act == 2'd2));

  a_r5_dly_set_on_reset: assert property (@(posedge clk) disable iff (por)
    rst_ext |=> dly_en);

  a_r8_run_reset_keeps_clock: assert property (@(posedge clk) disable iff (por)
    (rst_ext && clk_en) |=> (clk_en && !ready));

  a_r10_reset_wins: assert property (@(posedge clk) disable iff (por)
    (state == ST_STOP && rst_ext) |=> (wake_act == 2'd3 && !clk_en));

  a_r11_stop_blocked: assert property (@(posedge clk) disable iff (por)
    (state == ST_RUN && stop_req && (rst_ext || nmi_lvl || (irq_lvl && !mask_i))) |=> clk_en);

  a_r12_ready_single: assert property (@(posedge clk) disable iff (por)
    ready |=> !ready);

  a_r12_ready_on_rise: assert property (@(posedge clk) disable iff (por)
    $rose(clk_en) |-> ready);

  a_r12_ready_needs_clock: assert property (@(posedge clk) disable iff (por)
    ready |-> clk_en);
endmodule

bind stop_wake_ctrl swc_checker u_chk (
  .clk      (clk),
  .por      (por),
  .rst_ext  (rst_ext),
  .stop_req (stop_req),
  .irq_lvl  (irq_lvl),
  .nmi_lvl  (nmi_lvl),
  .mask_i   (mask_i),
  .mask_x   (mask_x),
  .clk_en   (clk_en),
  .wake_act (wake_act),
  .ready    (ready),
  .dly_en   (dly_en),
  .state    (state)
);

// File: tb/sim_stop_wake_ctrl.sv
module sim_stop_wake_ctrl;
  localparam int STAB = 10;
  localparam int NV   = 8;
  // Row bits: {dly, mask_i, mask_x, irq, nmi, rst, act[1:0]}
  localparam logic [7:0] VEC [NV] = '{
    8'b0_0_0_1_0_0_01,  // R1 R3 irq unmasked, no delay
    8'b1_0_1_1_0_0_01,  // R3 R6 irq with delay
    8'b0_0_0_0_1_0_01,  // R2 R3 nmi X clear
    8'b0_1_1_0_1_0_10,  // R2 R4 nmi X set
    8'b1_1_1_0_1_0_10,  // R4 R6 nmi X set with delay
    8'b0_0_1_1_1_0_10,  // R10 nmi over irq
    8'b0_0_0_1_1_1_11,  // R9 R10 reset over all
    8'b0_1_0_1_1_0_01   // R1 R10 masked irq, nmi wins
  };

  logic clk = 1'b0;
  logic por = 1'b1, rst_ext = 1'b0, stop_req = 1'b0;
  logic irq_lvl = 1'b0, nmi_lvl = 1'b0, mask_i = 1'b0, mask_x = 1'b0;
  logic dly_we = 1'b0, dly_d = 1'b0;
  logic clk_en, ready, dly_en;
  logic [1:0] wake_act;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  stop_wake_ctrl #(.STAB_CYCLES(STAB)) u0 (
    .clk(clk), .por(por), .rst_ext(rst_ext), .stop_req(stop_req),
    .irq_lvl(irq_lvl), .nmi_lvl(nmi_lvl), .mask_i(mask_i), .mask_x(mask_x),
    .dly_we(dly_we), .dly_d(dly_d), .clk_en(clk_en), .wake_act(wake_act),
    .ready(ready), .dly_en(dly_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, act=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_dly(input logic v);
    dly_we = 1'b1; dly_d = v;
    step();
    dly_we = 1'b0;
  endtask

  task automatic go_stop();
    stop_req = 1'b1;
    step();
    stop_req = 1'b0;
    chk("R11 clk_en after stop", clk_en, 0);
    chk("R11 act after stop", wake_act, 0);
  endtask

  // Count edges from the one sampling the wake until clk_en is seen high.
  task automatic wait_clk(output int n);
    n = 0;
    for (int k = 0; k < 100; k++) begin
      step();
      n++;
      irq_lvl = 1'b0; nmi_lvl = 1'b0; rst_ext = 1'b0;
      if (clk_en) break;
    end
  endtask

  initial begin
    int n;
    logic [7:0] v;
    // Reset state, R7
    step(); step();
    chk("R7 clk_en in por", clk_en, 0);
    chk("R7 ready in por", ready, 0);
    chk("R5 dly_en in por", dly_en, 1);
    chk("R7 act in por", wake_act, 3);
    por = 1'b0;
    n = 0;
    for (int k = 0; k < 100; k++) begin step(); n++; if (clk_en) break; end
    chk("R7 por delay edges", n, STAB + 1);
    chk("R12 ready at clock return", ready, 1);
    step();
    chk("R12 ready one cycle", ready, 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      set_dly(v[7]);
      chk("R5 dly write", dly_en, v[7]);
      go_stop();
      mask_i = v[6]; mask_x = v[5];
      irq_lvl = v[4]; nmi_lvl = v[3]; rst_ext = v[2];
      wait_clk(n);
      chk("R6 R9 R10 wake edges", n, (v[7] || v[2]) ? STAB + 2 : 1);
      chk("R3 R4 R10 wake action", wake_act, v[1:0]);
      chk("R12 ready with clock", ready, 1);
      step();
      chk("R12 ready drops", ready, 0);
      if (v[2]) chk("R9 dly set by stop reset", dly_en, 1);
      mask_i = 1'b0; mask_x = 1'b0;
    end

    // R1: masked irq holds stop, then unmasking wakes
    set_dly(1'b0);
    go_stop();
    mask_i = 1'b1; irq_lvl = 1'b1;
    for (int k = 0; k < 5; k++) step();
    chk("R1 masked irq no wake", clk_en, 0);
    mask_i = 1'b0;
    step();
    chk("R1 unmasked irq wakes", clk_en, 1);
    chk("R3 irq service code", wake_act, 1);
    irq_lvl = 1'b0;
    step();

    // R11: stop ignored while wake active
    stop_req = 1'b1; irq_lvl = 1'b1;
    step();
    chk("R11 stop blocked by irq", clk_en, 1);
    chk("R11 act unchanged", wake_act, 1);
    irq_lvl = 1'b0; nmi_lvl = 1'b1;
    step();
    chk("R11 stop blocked by nmi", clk_en, 1);
    stop_req = 1'b0; nmi_lvl = 1'b0;
    step();

    // R8: reset while running
    set_dly(1'b0);
    rst_ext = 1'b1;
    step();
    rst_ext = 1'b0;
    chk("R8 clk_en kept", clk_en, 1);
    chk("R8 no ready", ready, 0);
    chk("R8 act none", wake_act, 0);
    chk("R5 dly set by run reset", dly_en, 1);

    // R7: power-on applies delay even with dly cleared
    set_dly(1'b0);
    por = 1'b1;
    step();
    por = 1'b0;
    n = 0;
    for (int k = 0; k < 100; k++) begin step(); n++; if (clk_en) break; end
    chk("R7 por delay despite dly0", n, STAB + 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule